// File: doc/BRIEF.md
# Qualified Bus Trace Capture Pipeline

This block takes a snapshot of a wide processor bus on every rising edge of the bus clock. Each snapshot moves through a fixed three-stage pipeline to a trace-memory write port. The snapshot holds the bus data group, a request group and a bus-activity flag. In the middle stage, a four-bit status word is built from the first-stage sample and the one before it. The status word is registered once and then joins its data at the storage stage. Because of that, the status path is one register shorter than the data path.

A clock qualifier decides which of the aligned entries are written, and it has two settings. Expanded mode writes an entry on every clock once the pipeline has filled. Compacted mode leaves out idle clocks, so a fixed memory depth holds a longer stretch of bus traffic. A clock counts as idle when the activity flag is low and no status bit is set. Each written entry carries a saturating count of the idle clocks left out just before it, so elapsed time can be rebuilt from the trace. The request group is captured and stored with the entry, but it is meant only for the status logic and not for display.

Top module: `bus_trace_pipe`

## Requirements
- R1: The data group and request group seen on the pins at rising edge k appear on `store_data` and `store_req` after rising edge k+2, which is three register stages.
- R2: The status word of sample k has four bits. Bit 0 is set when any request bit of sample k is set. Bit 1 is set when the data of sample k differs from the data of sample k-1. Bit 2 is set when activity is high in sample k and was low in sample k-1. Bit 3 is set when activity is low in sample k and was high in sample k-1. Where this is the first sample after reset, sample k-1 counts as inactive and unchanged.
- R3: `store_status` always belongs to the same sample as `store_data` on the same clock.
- R4: In expanded mode (`compact_mode` = 0) `store_en` is high on every clock once the pipeline has filled.
- R5: In compacted mode (`compact_mode` = 1), `store_en` stays low for a sample whose activity flag is low and whose status word is zero. For every other sample, `store_en` is high.
- R6: `store_gap` on a written entry gives the number of samples left out since the previous written entry. The count saturates at 2^GAP_W-1 and restarts from zero after each written entry.
- R7: While `rst` is high and for the first two rising edges after it falls, `store_en` is low and all outputs are zero. The first strobe can come after the third edge.
- R8: The qualifier setting is sampled on the edge that moves an entry into the storage stage, so a mode change takes effect entry by entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | DATA_W | Main bus data group |
| bus_req | input | REQ_W | Request signal group |
| bus_active | input | 1 | Bus-activity indicator |
| compact_mode | input | 1 | 1 = compacted qualifier, 0 = expanded |
| store_en | output | 1 | Qualified trace-memory write strobe |
| store_data | output | DATA_W | Aligned data group |
| store_req | output | REQ_W | Aligned request group (not for display) |
| store_status | output | 4 | Status word of the aligned sample |
| store_gap | output | GAP_W | Idle clocks left out before this entry |

## Verification
The bench sends random traffic in both modes and runs a long idle stretch to reach saturation of the gap count. A design whose status path was one stage too deep would report a change flag, or an activity edge, one entry late. It would then drop or keep the wrong clocks in compacted mode. The bench also checks the first strobe after reset, because one with a missing valid stage would write a garbage entry. It switches modes during traffic, and a design that sampled the mode at the wrong stage would qualify entries that lie next to the switch wrongly. The saturation test also covers a gap counter that wraps instead of holding at its maximum, which would show a small gap after a long idle run.

// File: rtl/bus_trace_pipe.sv
module bus_trace_pipe #(
  parameter int DATA_W = 32,
  parameter int REQ_W  = 5,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [REQ_W-1:0]  bus_req,
  input  logic              bus_active,
  input  logic              compact_mode,
  output logic              store_en,
  output logic [DATA_W-1:0] store_data,
  output logic [REQ_W-1:0]  store_req,
  output logic [3:0]        store_status,
  output logic [GAP_W-1:0]  store_gap
);
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

  logic              s1_v, s2_v;
  logic [DATA_W-1:0] s1_data, s2_data;
  logic [REQ_W-1:0]  s1_req, s2_req;
  logic              s1_act, s2_act;
  logic [3:0]        stat_d, stat_q;
  logic [GAP_W-1:0]  gap_cnt;
  logic              idle2, keep2;

  // stage 1: pin capture
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_data <= '0; s1_req <= '0; s1_act <= 1'b0;
    end else begin
      s1_v <= 1'b1; s1_data <= bus_data; s1_req <= bus_req; s1_act <= bus_active;
    end
  end

  // status from the stage-1 sample against the previous one (held in stage 2)
  assign stat_d[0] = s1_v & (|s1_req);
  assign stat_d[1] = s1_v & s2_v & (s1_data != s2_data);
  assign stat_d[2] = s1_v & s1_act & ~s2_act;
  assign stat_d[3] = s1_v & ~s1_act & s2_act;

  // stage 2: second register for data, status register for derived bits
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0; s2_data <= '0; s2_req <= '0; s2_act <= 1'b0; stat_q <= '0;
    end else begin
      s2_v <= s1_v; s2_data <= s1_data; s2_req <= s1_req; s2_act <= s1_act;
      stat_q <= stat_d;
    end
  end

  assign idle2 = ~s2_act & (stat_q == 4'b0000);
  assign keep2 = ~compact_mode | ~idle2;

  // stage 3: qualified store
  always_ff @(posedge clk) begin
    if (rst) begin
      store_en <= 1'b0; store_data <= '0; store_req <= '0;
      store_status <= '0; store_gap <= '0; gap_cnt <= '0;
    end else begin
      store_en <= s2_v & keep2;
      if (s2_v) begin
        store_data   <= s2_data;
        store_req    <= s2_req;
        store_status <= stat_q;
        if (keep2) begin
          store_gap <= gap_cnt;
          gap_cnt   <= '0;
        end else if (gap_cnt != GAP_MAX) begin
          gap_cnt <= GAP_W'(gap_cnt + 1'b1);
        end
      end
    end
  end

  AST_FIRST_FILL_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    $rose(s2_v) |-> !store_en); // R7
  AST_STATUS_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    !s2_v |-> stat_q == 4'b0000); // R2
  AST_EXPANDED_EVERY: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!compact_mode) && $past(store_en)) |-> store_en); // R4
  AST_EXPANDED_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && store_en && $past(!compact_mode) && $past(store_en)) |-> store_gap == '0); // R6
  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(s2_v) && !store_en && $past(gap_cnt) != GAP_MAX)
      |-> gap_cnt == GAP_W'($past(gap_cnt) + 1'b1)); // R5
endmodule

// File: tb/bus_trace_pipe_tb.sv
module bus_trace_pipe_tb_top;
  localparam int DW = 32, RW = 5, GW = 8, N = 4096;
  localparam int GMAX = (1 << GW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [DW-1:0] bus_data = '0;
  logic [RW-1:0] bus_req = '0;
  logic bus_active = 1'b0, compact_mode = 1'b0;
  logic store_en;
  logic [DW-1:0] store_data;
  logic [RW-1:0] store_req;
  logic [3:0] store_status;
  logic [GW-1:0] store_gap;

  bus_trace_pipe #(.DATA_W(DW), .REQ_W(RW), .GAP_W(GW)) dut_i (
    .clk(clk), .rst(rst), .bus_data(bus_data), .bus_req(bus_req),
    .bus_active(bus_active), .compact_mode(compact_mode), .store_en(store_en),
    .store_data(store_data), .store_req(store_req), .store_status(store_status),
    .store_gap(store_gap));

  always #5 clk = ~clk;

  logic [DW-1:0] hd [0:N-1];
  logic [RW-1:0] hr [0:N-1];
  logic          ha [0:N-1];
  logic          hm [0:N-1];
  int checks = 0, fails = 0, e = 0, gcnt = 0, exp_gap = 0;
  int unsigned seed = 32'h1357;
  logic [DW-1:0] last_d = '0;

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (edge %0d)", req, got, exp, e);
    end
  endtask

  function automatic logic [3:0] exp_stat(int j);
    logic pa;
    logic [3:0] s;
    pa = (j > 0) ? ha[j-1] : 1'b0;
    s[0] = |hr[j];
    s[1] = (j > 0) && (hd[j] != hd[j-1]);
    s[2] = ha[j] && !pa;
    s[3] = !ha[j] && pa;
    return s;
  endfunction

  function automatic logic exp_keep(int j, logic m);
    return !m || ha[j] || (exp_stat(j) != 4'b0000);
  endfunction

  task automatic check_outputs();
    int j;
    logic k;
    if (e < 3) begin
      chk("R7 no early store", store_en, 0);
      chk("R7 data zero", store_data, 0);
      return;
    end
    j = e - 3;
    k = exp_keep(j, hm[e-1]);
    chk("R1 data", store_data, hd[j]);
    chk("R1 req", store_req, hr[j]);
    chk("R2 R3 status", store_status, exp_stat(j));
    chk(hm[e-1] ? "R5 R8 compact strobe" : "R4 R8 expanded strobe", store_en, k);
    if (k) begin
      exp_gap = gcnt; gcnt = 0;
      chk("R6 gap", store_gap, exp_gap);
    end else if (gcnt < GMAX) gcnt++;
  endtask

  task automatic step(logic [DW-1:0] d, logic [RW-1:0] r, logic a, logic m);
    @(negedge clk);
    check_outputs();
    bus_data = d; bus_req = r; bus_active = a; compact_mode = m;
    if (e < N) begin hd[e] = d; hr[e] = r; ha[e] = a; hm[e] = m; end
    @(posedge clk);
    e++;
  endtask

  task automatic rnd(int n, logic m, int act_pct);
    for (int i = 0; i < n; i++) begin
      logic a;
      logic [RW-1:0] r;
      a = ($urandom(seed) % 100) < act_pct;
      seed = seed + 1;
      r = (($urandom() % 8) == 0) ? RW'($urandom()) : '0;
      if (($urandom() % 3) == 0) last_d = $urandom();
      step(last_d, r, a, m);
    end
  endtask

  initial begin
    void'($urandom(seed));
    repeat (3) begin
      @(negedge clk);
      chk("R7 reset strobe", store_en, 0);
      chk("R7 reset gap", store_gap, 0);
    end
    @(negedge clk); rst = 1'b0;
    @(posedge clk);
    e = 0;
    hd[0] = bus_data; hr[0] = bus_req; ha[0] = bus_active; hm[0] = compact_mode;
    e = 1;
    rnd(300, 1'b0, 60);
    rnd(400, 1'b1, 30);
    for (int i = 0; i < 20; i++) rnd(7, i[0], 40);
    for (int i = 0; i < 300; i++) step(last_d, '0, 1'b0, 1'b1);
    step(~last_d, '0, 1'b1, 1'b1);
    last_d = ~last_d;
    for (int i = 0; i < 40; i++) step(last_d, '0, 1'b0, 1'b1);
    step(last_d, 5'b00100, 1'b0, 1'b1);
    rnd(400, 1'b1, 10);
    rnd(200, 1'b0, 20);
    repeat (3) step(last_d, '0, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule